// File: doc/BRIEF.md
# Early-Terminating Long Multiplier

This block forms the full 64-bit product of two 32-bit operands, treating them either as unsigned or as two's-complement values. On request it also adds a 64-bit addend to the product. The datapath holds a single 32x16 partial-product multiplier and a single 32-bit adder with carry. A product therefore takes one or two passes through the multiplier, and every 64-bit correction or accumulation is done as 32-bit word steps. The block skips whatever work the operand values make unnecessary, so its latency depends on the data.

An operation begins with a one-cycle `start` while the block is idle. The sequence is:

- a setup cycle, which classifies the operands and converts signed values to magnitudes;
- one or two partial-product cycles;
- a finalize cycle, which begins the sign fix;
- an optional cycle that completes the sign fix in the upper word;
- one or two optional accumulate cycles.

When the operation ends, the block raises `done` for one cycle and holds `result` until a later operation completes.

Top module: `etm_long_mul`

## Requirements
- R1: With `is_signed`=0 and `do_acc`=0, `result` equals the unsigned 64-bit product of `op_a` and `op_b`.
- R2: With `is_signed`=1 and `do_acc`=0, `result` equals the two's-complement 64-bit product of `op_a` and `op_b`, with both operands sign-extended from bit 31.
- R3: With `do_acc`=1, `result` equals the product defined by R1 or R2 plus `addend`, taken modulo 2^64.
- R4: Latency is counted from the rising edge that samples `start` to the rising edge after which `done` is high. For `do_acc`=0 the latency is 3, plus 1 when the operation needs a second pass, plus 1 when it needs a sign fix. A second pass is needed only when both operands are wide and both are nonzero. A sign fix is needed only when `is_signed`=1, bit 31 differs between the operands, and both operands are nonzero.
- R5: An operand counts as narrow in signed mode when its bits [31:15] are all equal. It counts as narrow in unsigned mode when its bits [31:16] are all zero. One narrow operand is enough to avoid the second pass, and it does not matter which operand it is.
- R6: When either operand is zero, the block performs neither the second pass nor the sign fix, so the latency without accumulation is 3.
- R7: With `do_acc`=1, the latency is the R4 latency plus 1. It rises by 1 more unless `addend[63:32]` is zero and adding `addend[31:0]` to the low product word gives no carry out.
- R8: `done` is high for exactly one cycle per operation. `result` changes only on the edge that raises `done`, and it holds its value while `done` is low.
- R9: A `start` that arrives while an operation is in progress is ignored. The current result is unaffected, and no extra `done` occurs.
- R10: While `rst` is high and after it is released, `done` is 0 and `result` is 0 until the first operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; honoured only when idle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| do_acc | input | 1 | 1: add `addend` to the product |
| addend | input | 64 | Value added to the product when `do_acc`=1 |
| result | output | 64 | Registered result of the last completed operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle several properties:

- `done` is a single-cycle pulse, and `result` moves only with it;
- a start that arrives mid-operation leaves the captured operands untouched;
- the second pass never runs with a zero magnitude;
- the sign fix runs only in signed mode;
- the high accumulate step runs only when it is needed;
- the total latency stays within 3 to 7 cycles.

Only the bench's scenarios can show that the product and accumulated sums are arithmetically right and that the exact cycle count follows the narrow, zero, sign and carry rules. The scenarios cover hand-picked boundary operands such as -32768, +32768, -1 and zero, accumulate carries, and a pseudo-random mix of operand widths.

// File: rtl/etm_pkg.sv
package etm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PP_LO,
    ST_PP_HI,
    ST_FIN,
    ST_NEGH,
    ST_ACC_LO,
    ST_ACC_HI
  } etm_state_e;
endpackage

// File: rtl/etm_classify.sv
module etm_classify #(
  parameter int DW = 32,
  localparam int SW = DW / 2
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sgn,
  output logic [DW-1:0] mag_x,
  output logic [DW-1:0] mag_y,
  output logic          wide,
  output logic          neg
);
  logic          a_neg, b_neg, a_nz, b_nz, a_nar, b_nar;
  logic [DW-1:0] mag_a, mag_b;
  logic [DW-SW:0] a_top, b_top;

  assign a_neg = sgn & a[DW-1];
  assign b_neg = sgn & b[DW-1];
  assign mag_a = a_neg ? (~a + 1'b1) : a;
  assign mag_b = b_neg ? (~b + 1'b1) : b;
  assign a_nz  = |a;
  assign b_nz  = |b;

  // Top bits including the slice sign bit, for the signed narrow test.
  assign a_top = a[DW-1:SW-1];
  assign b_top = b[DW-1:SW-1];
  assign a_nar = sgn ? ((&a_top) | ~(|a_top)) : ~(|a[DW-1:SW]);
  assign b_nar = sgn ? ((&b_top) | ~(|b_top)) : ~(|b[DW-1:SW]);

  // Narrow operand goes to the sliced position so one pass suffices.
  always_comb begin
    if (!b_nar && a_nar) begin
      mag_x = mag_b;
      mag_y = mag_a;
    end else begin
      mag_x = mag_a;
      mag_y = mag_b;
    end
  end

  assign wide = ~a_nar & ~b_nar & a_nz & b_nz;
  assign neg  = (a_neg ^ b_neg) & a_nz & b_nz;
endmodule

// File: rtl/etm_pp.sv
module etm_pp #(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic [DW-1:0]    x,
  input  logic [SW-1:0]    s,
  output logic [DW+SW-1:0] p
);
  assign p = {{SW{1'b0}}, x} * {{DW{1'b0}}, s};
endmodule

// File: rtl/etm_addc.sv
module etm_addc #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  assign sum  = full[DW-1:0];
  assign cout = full[DW];
endmodule

// File: rtl/etm_long_mul.sv
module etm_long_mul
  import etm_pkg::*;
#(
  parameter int DW = 32,
  localparam int SW = DW / 2,
  localparam int PW = 2 * DW,
  localparam int XW = PW - DW - SW,
  localparam int MAXLAT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          is_signed,
  input  logic          do_acc,
  input  logic [PW-1:0] addend,
  output logic [PW-1:0] result,
  output logic          done
);
  etm_state_e    state;
  logic [DW-1:0] op_a_q, op_b_q, mag_x_q, mag_y_q;
  logic          sgn_q, acc_q, wide_q, neg_q, carry_q;
  logic [PW-1:0] add_q, prod_q;
  logic [3:0]    cyc_q;

  logic [DW-1:0]    c_mag_x, c_mag_y;
  logic             c_wide, c_neg;
  logic [SW-1:0]    slice;
  logic [DW+SW-1:0] pp;
  logic [DW-1:0]    ad_a, ad_b, ad_sum;
  logic             ad_cin, ad_cout;
  logic [PW-1:0]    nxt_prod;
  logic             last;
  etm_state_e       nxt_state;

  etm_classify #(.DW(DW)) u_cls (
    .a(op_a_q), .b(op_b_q), .sgn(sgn_q),
    .mag_x(c_mag_x), .mag_y(c_mag_y), .wide(c_wide), .neg(c_neg)
  );

  assign slice = (state == ST_PP_HI) ? mag_y_q[DW-1:SW] : mag_y_q[SW-1:0];

  etm_pp #(.DW(DW), .SW(SW)) u_pp (.x(mag_x_q), .s(slice), .p(pp));

  etm_addc #(.DW(DW)) u_add (
    .a(ad_a), .b(ad_b), .cin(ad_cin), .sum(ad_sum), .cout(ad_cout)
  );

  // Shared 32-bit adder: sign fix and accumulate, one word per cycle.
  always_comb begin
    ad_a      = '0;
    ad_b      = '0;
    ad_cin    = 1'b0;
    nxt_prod  = prod_q;
    last      = 1'b0;
    nxt_state = ST_IDLE;
    case (state)
      ST_FIN: begin
        ad_a      = neg_q ? ~prod_q[DW-1:0] : prod_q[DW-1:0];
        ad_cin    = neg_q;
        nxt_prod  = {prod_q[PW-1:DW], ad_sum};
        last      = !neg_q && !acc_q;
        nxt_state = neg_q ? ST_NEGH : ST_ACC_LO;
      end
      ST_NEGH: begin
        ad_a      = ~prod_q[PW-1:DW];
        ad_cin    = carry_q;
        nxt_prod  = {ad_sum, prod_q[DW-1:0]};
        last      = !acc_q;
        nxt_state = ST_ACC_LO;
      end
      ST_ACC_LO: begin
        ad_a      = prod_q[DW-1:0];
        ad_b      = add_q[DW-1:0];
        nxt_prod  = {prod_q[PW-1:DW], ad_sum};
        last      = ~(|add_q[PW-1:DW]) & ~ad_cout;
        nxt_state = ST_ACC_HI;
      end
      ST_ACC_HI: begin
        ad_a      = prod_q[PW-1:DW];
        ad_b      = add_q[PW-1:DW];
        ad_cin    = carry_q;
        nxt_prod  = {ad_sum, prod_q[DW-1:0]};
        last      = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_a_q  <= '0;
      op_b_q  <= '0;
      sgn_q   <= 1'b0;
      acc_q   <= 1'b0;
      add_q   <= '0;
      mag_x_q <= '0;
      mag_y_q <= '0;
      wide_q  <= 1'b0;
      neg_q   <= 1'b0;
      carry_q <= 1'b0;
      prod_q  <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_a_q <= op_a;
          op_b_q <= op_b;
          sgn_q  <= is_signed;
          acc_q  <= do_acc;
          add_q  <= addend;
          state  <= ST_SETUP;
        end
        ST_SETUP: begin
          mag_x_q <= c_mag_x;
          mag_y_q <= c_mag_y;
          wide_q  <= c_wide;
          neg_q   <= c_neg;
          state   <= ST_PP_LO;
        end
        ST_PP_LO: begin
          prod_q <= {{XW{1'b0}}, pp};
          state  <= wide_q ? ST_PP_HI : ST_FIN;
        end
        ST_PP_HI: begin
          prod_q <= prod_q + ({{XW{1'b0}}, pp} << SW);
          state  <= ST_FIN;
        end
        default: begin
          prod_q  <= nxt_prod;
          carry_q <= ad_cout;
          if (last) begin
            result <= nxt_prod;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= nxt_state;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE) cyc_q <= '0;
    else                         cyc_q <= cyc_q + 1'b1;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> ($stable(op_a_q) && $stable(op_b_q) && $stable(add_q)));
  assert_zero_skips_second_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PP_HI) |-> (mag_x_q != '0 && mag_y_q != '0));
  assert_negate_only_signed_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NEGH) |-> sgn_q);
  assert_acc_hi_needed_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACC_HI) |-> (add_q[PW-1:DW] != '0 || carry_q));
  assert_latency_bound_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc_q >= 4'd3 && cyc_q <= 4'(MAXLAT)));
endmodule

// File: tb/etm_long_mul_tb.sv
`timescale 1ns/1ps
module etm_long_mul_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        is_signed = 1'b0, do_acc = 1'b0;
  logic [63:0] addend = '0;
  logic [63:0] result;
  logic        done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int dones = 0;
  logic prev_done = 1'b0;

  logic [63:0] exp_q[$];
  int          lat_q[$];
  int          t0_q[$];
  string       tag_q[$];
  string       ltag_q[$];

  etm_long_mul u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .is_signed(is_signed), .do_acc(do_acc), .addend(addend),
    .result(result), .done(done)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit is_narrow(logic [31:0] v, bit sgn);
    if (sgn) return ($signed(v) >= -32768) && ($signed(v) <= 32767);
    return v < 32'd65536;
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) check_int("R8 done width", 2, 1);
      if (done) begin
        dones++;
        if (exp_q.size() == 0) begin
          check_int("R9 unexpected done", 1, 0);
        end else begin
          check64(tag_q.pop_front(), result, exp_q.pop_front());
          check_int(ltag_q.pop_front(), cyc - t0_q.pop_front(), lat_q.pop_front());
        end
      end
    end
    prev_done <= done;
  end

  // Driver: computes expectations, pushes them, issues start.
  task automatic run_op(logic [31:0] a, logic [31:0] b, bit sgn, bit acc,
                        logic [63:0] ad, bit intrude);
    logic [63:0] prod, full;
    logic [32:0] lo_sum;
    int lat;
    prod = sgn ? ({{32{a[31]}}, a} * {{32{b[31]}}, b}) : ({32'b0, a} * {32'b0, b});
    full = acc ? prod + ad : prod;
    lat = 3;
    if (!is_narrow(a, sgn) && !is_narrow(b, sgn)) lat++;
    if (sgn && (a[31] != b[31]) && a != 0 && b != 0) lat++;
    if (acc) begin
      lat++;
      lo_sum = {1'b0, prod[31:0]} + {1'b0, ad[31:0]};
      if (ad[63:32] != 0 || lo_sum[32]) lat++;
    end
    @(negedge clk);
    op_a = a; op_b = b; is_signed = sgn; do_acc = acc; addend = ad;
    start = 1'b1;
    @(posedge clk);
    #1;
    exp_q.push_back(full);
    lat_q.push_back(lat);
    t0_q.push_back(cyc);
    tag_q.push_back(acc ? "R3 acc result" : (sgn ? "R2 signed result" : "R1 unsigned result"));
    ltag_q.push_back(acc ? "R7 acc latency" : "R4 latency");
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      op_a = ~a; op_b = b + 32'd12345; addend = ~ad; do_acc = ~acc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [63:0] held;
    int nd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_int("R10 done in reset", int'(done), 0);
    check64("R10 result in reset", result, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_int("R10 done after reset", int'(done), 0);
    check64("R10 result after reset", result, 64'd0);

    // R1 / R4 / R5 unsigned
    run_op(32'd1234, 32'd5678, 0, 0, 0, 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    run_op(32'hDEAD_BEEF, 32'h0000_FFFF, 0, 0, 0, 0);
    run_op(32'h0000_8001, 32'h1234_5678, 0, 0, 0, 0);   // R5 narrow first operand
    run_op(32'h0001_0000, 32'h0001_0000, 0, 0, 0, 0);
    // R6 zero operand
    run_op(32'd0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    run_op(32'h8000_0000, 32'd0, 1, 0, 0, 0);
    run_op(32'd0, 32'h8765_4321, 1, 0, 0, 0);
    // R2 signed, R5 boundaries
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 0);
    run_op(32'hFFFF_8000, 32'h7FFF_FFFF, 1, 0, 0, 0);
    run_op(32'h0000_8000, 32'h0000_8000, 1, 0, 0, 0);
    run_op(32'h8000_0000, 32'h8000_0000, 1, 0, 0, 0);
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 1, 0, 0, 0);
    run_op(32'hFFFF_FFFE, 32'd300, 1, 0, 0, 0);
    // R3 / R7 accumulate
    run_op(32'd100, 32'd200, 0, 1, 64'd5, 0);
    run_op(32'd100, 32'd200, 0, 1, 64'h0000_0000_FFFF_FFFF, 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run_op(32'h8000_0001, 32'h7FFF_0000, 1, 1, 64'h8000_0000_0000_0001, 0);
    run_op(32'd0, 32'd0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);

    // R9 start while busy
    nd = dones;
    run_op(32'h1357_9BDF, 32'h2468_ACE0, 0, 0, 0, 1);
    run_op(32'hFFFF_0001, 32'h0002_0003, 1, 1, 64'h1, 1);
    repeat (10) @(negedge clk);
    check_int("R9 done count", dones - nd, 2);

    // R8 result holds while idle
    held = result;
    @(negedge clk);
    op_a = 32'h55; op_b = 32'h66;
    repeat (6) @(negedge clk);
    check64("R8 result hold", result, held);

    // Mixed-width pseudo-random operands
    s = 32'hACE1_2468;
    for (int i = 0; i < 48; i++) begin
      logic [31:0] ra, rb;
      logic [63:0] rd;
      s = s ^ (s << 13); s = s ^ (s >> 17); ra = s;
      s = s ^ (s << 5);  rb = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); rd = {s, ra ^ rb};
      if (i % 3 == 0) ra = {{16{ra[15]}}, ra[15:0]};
      if (i % 4 == 1) rb = {16'd0, rb[15:0]};
      if (i % 7 == 2) rd[63:32] = 32'd0;
      run_op(ra, rb, i[0], i[1], rd, 0);
    end

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule